// File: doc/BRIEF.md
# Receive Mailbox Allocator With Overwrite

This block places each accepted incoming bus frame into one mailbox of a small bank. A bus engine outside the block delivers the frame: a one-cycle strobe with an identifier, a format flag, a length, a remote flag and eight data bytes. Each mailbox has a 2-bit operating mode, an identifier and an acceptance mask. The block filters the frame against every mailbox. It stores the frame in the lowest-numbered mailbox that accepts the frame and is empty. A mailbox that holds a frame stays closed until software re-arms it through a bitmask command.

One or more mailboxes can run in overwrite mode. A mailbox in this mode is used only when no accepting mailbox is empty. In that case it replaces its unread contents and raises a message-lost flag. This gives the bank a last-resort slot that always takes the newest frame. When a frame is accepted by some enabled mailbox but no mailbox can take it, the frame is dropped and a sticky overflow flag is set. A read port returns the status, identifier and data of the mailbox that `rd_sel` names.

Top module: `rxmb_alloc`

## Requirements
- R1: A frame is stored in the lowest-numbered mailbox that accepts its identifier, is enabled for reception and is empty. A frame lands in at most one mailbox.
- R2: Mailbox i takes its mode from `cfg_mode[2i+1:2i]`: 0 is off, 1 is normal receive, 2 is receive with overwrite, and 3 is treated as off. A mailbox in mode 0 or 3 never stores a frame.
- R3: A full mailbox in mode 1 takes no further frame until it is re-armed. A frame that would have matched it goes to the next mailbox that qualifies.
- R4: When no accepting mailbox is empty, the lowest-numbered accepting mailbox in mode 2 is overwritten and its lost flag is set (`mb_lost[i]`, status bit 24).
- R5: Identifiers use a 30-bit register format. Bit 29 set marks an extended frame, and the 29-bit identifier sits in bits 28:0. Bit 29 clear marks a standard frame, whose 11-bit identifier (`frm_id[10:0]`) sits in bits 28:18 with zeros below. A mailbox accepts a frame when ((frame ID xor mailbox ID) and mask) is zero over all 30 bits. An all-zero mask therefore accepts both formats.
- R6: For the selected mailbox, `rd_status` holds the length in bits 19:16, the remote flag in bit 20, ready in bit 23 and lost in bit 24, with every other bit zero. `rd_id` holds the stored frame ID in register format. `rd_data_lo` holds bytes 0..3 (`frm_data[31:0]`) and `rd_data_hi` holds bytes 4..7 (`frm_data[63:32]`).
- R7: Each set bit of `rearm_mask` clears that mailbox's ready and lost flags at the next edge, and one command may re-arm several mailboxes. A frame in the same cycle sees the mailbox states from before the re-arm. If that frame lands in a mailbox being re-armed, the store wins.
- R8: `mb_rx_irq[i]` pulses high for exactly one cycle after a frame is stored in mailbox i, whether the store is a normal one or an overwrite.
- R9: `overflow` is set when a frame is accepted by at least one enabled mailbox but stored in none. A frame that every mailbox rejects leaves it unchanged. Only reset clears it.
- R10: After reset all ready, lost, interrupt and overflow flags are zero and all mailbox contents are zero.
- R11: All flags and contents update on the clock edge that samples `frm_valid`, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | Received-frame strobe, one cycle per frame |
| frm_ext | input | 1 | Frame uses the extended identifier format |
| frm_id | input | 29 | Received identifier; only bits 10:0 are used for standard frames |
| frm_len | input | 4 | Received length code |
| frm_rtr | input | 1 | Received remote-frame flag |
| frm_data | input | 64 | Received data, byte 0 in bits 7:0 |
| cfg_mode | input | 2*NUM_MB | Per-mailbox mode fields |
| cfg_id | input | 30*NUM_MB | Per-mailbox identifier in register format |
| cfg_mask | input | 30*NUM_MB | Per-mailbox acceptance mask |
| rearm_mask | input | NUM_MB | Re-arm command, one bit per mailbox |
| rd_sel | input | IDX_W | Mailbox shown on the read port |
| mb_ready | output | NUM_MB | Mailbox holds an unread frame |
| mb_lost | output | NUM_MB | Mailbox was overwritten while full |
| mb_rx_irq | output | NUM_MB | Per-mailbox store pulse |
| overflow | output | 1 | Sticky dropped-frame flag |
| rd_status | output | 32 | Status word of the selected mailbox |
| rd_id | output | 30 | Stored identifier of the selected mailbox |
| rd_data_lo | output | 32 | Data bytes 0..3 of the selected mailbox |
| rd_data_hi | output | 32 | Data bytes 4..7 of the selected mailbox |

## Verification
The assertions check several rules on every cycle:
- at most one mailbox stores each frame;
- no store pulse appears without a frame;
- an off or reserved mailbox never pulses;
- a full normal mailbox stays closed unless re-armed;
- the lost flag never stands without ready;
- re-arming empties a mailbox;
- overflow never falls.

Other behaviour needs the bench's scenarios, run against a behavioural model:
- the lowest-index search;
- the fallback to overwrite only after the bank is full;
- the identifier format and mask decisions for both frame kinds;
- the dropped-versus-rejected distinction for overflow;
- re-arming in the same cycle as a frame;
- the read-port contents.

// File: rtl/rxmb_pkg.sv
package rxmb_pkg;

    localparam int RID_W   = 30;   // identifier width in register format
    localparam int XID_W   = 29;   // extended identifier width
    localparam int EXT_POS = 29;   // format flag position
    localparam int SID_W   = 11;   // standard identifier width
    localparam int SID_LSB = 18;   // standard identifier placement
    localparam int LEN_W   = 4;
    localparam int DATA_W  = 64;

    typedef enum logic [1:0] {
        MB_OFF = 2'd0,
        MB_RX  = 2'd1,
        MB_OVR = 2'd2,
        MB_RSV = 2'd3
    } mb_mode_e;

    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic              rtr;
        logic [RID_W-1:0]  id;
        logic [DATA_W-1:0] data;
    } mb_rec_t;

    // Map a received identifier into the 30-bit register layout.
    function automatic logic [RID_W-1:0] make_reg_id(input logic ext,
                                                     input logic [XID_W-1:0] id);
        logic [RID_W-1:0] r;
        if (ext) begin
            r = {1'b1, id};
        end else begin
            r = {1'b0, id[SID_W-1:0], {SID_LSB{1'b0}}};
        end
        return r;
    endfunction

endpackage

// File: rtl/rxmb_filter.sv
module rxmb_filter
    import rxmb_pkg::*;
#(
    parameter int NUM_MB = 8
) (
    input  logic [RID_W-1:0]        frame_id,
    input  logic [NUM_MB*RID_W-1:0] cfg_id,
    input  logic [NUM_MB*RID_W-1:0] cfg_mask,
    input  logic [2*NUM_MB-1:0]     cfg_mode,
    input  logic [NUM_MB-1:0]       ready_q,
    output logic [NUM_MB-1:0]       free_o,   // accepts, enabled, empty
    output logic [NUM_MB-1:0]       ovr_o,    // accepts, overwrite mode
    output logic [NUM_MB-1:0]       elig_o    // accepts, enabled
);

    for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
        logic [RID_W-1:0] id_i;
        logic [RID_W-1:0] mask_i;
        logic [1:0]       mode_i;
        logic             match_i;
        logic             rx_en_i;

        assign id_i    = cfg_id[i*RID_W +: RID_W];
        assign mask_i  = cfg_mask[i*RID_W +: RID_W];
        assign mode_i  = cfg_mode[2*i +: 2];
        assign match_i = ((frame_id ^ id_i) & mask_i) == '0;
        assign rx_en_i = (mode_i == MB_RX) || (mode_i == MB_OVR);

        assign free_o[i] = match_i & rx_en_i & ~ready_q[i];
        assign ovr_o[i]  = match_i & (mode_i == MB_OVR);
        assign elig_o[i] = match_i & rx_en_i;
    end

endmodule

// File: rtl/rxmb_first_set.sv
module rxmb_first_set #(
    parameter int NUM_MB = 8,
    localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
    input  logic [NUM_MB-1:0] vec_i,
    output logic              found_o,
    output logic [IDX_W-1:0]  idx_o
);

    // Lowest set bit wins: scan downward so the last hit is the lowest.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NUM_MB - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/rxmb_bank.sv
module rxmb_bank
    import rxmb_pkg::*;
#(
    parameter int NUM_MB = 8,
    localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  store_i,
    input  logic [IDX_W-1:0]      idx_i,
    input  logic                  over_i,
    input  logic                  drop_i,
    input  logic [NUM_MB-1:0]     rearm_i,
    input  mb_rec_t               rec_i,
    output logic [NUM_MB-1:0]     ready_o,
    output logic [NUM_MB-1:0]     lost_o,
    output logic [NUM_MB-1:0]     irq_o,
    output logic                  ovf_o,
    output mb_rec_t [NUM_MB-1:0]  rec_o
);

    typedef struct packed {
        logic [NUM_MB-1:0]    ready;
        logic [NUM_MB-1:0]    lost;
        logic [NUM_MB-1:0]    irq;
        logic                 ovf;
        mb_rec_t [NUM_MB-1:0] rec;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.irq   = '0;
        st_d.ready = st_q.ready & ~rearm_i;
        st_d.lost  = st_q.lost  & ~rearm_i;
        if (store_i) begin
            st_d.ready[idx_i] = 1'b1;
            st_d.lost[idx_i]  = over_i;
            st_d.irq[idx_i]   = 1'b1;
            st_d.rec[idx_i]   = rec_i;
        end
        if (drop_i) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready_o = st_q.ready;
    assign lost_o  = st_q.lost;
    assign irq_o   = st_q.irq;
    assign ovf_o   = st_q.ovf;
    assign rec_o   = st_q.rec;

endmodule

// File: rtl/rxmb_alloc.sv
module rxmb_alloc
    import rxmb_pkg::*;
#(
    parameter int NUM_MB = 8,
    localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frm_valid,
    input  logic                    frm_ext,
    input  logic [XID_W-1:0]        frm_id,
    input  logic [LEN_W-1:0]        frm_len,
    input  logic                    frm_rtr,
    input  logic [DATA_W-1:0]       frm_data,
    input  logic [2*NUM_MB-1:0]     cfg_mode,
    input  logic [NUM_MB*RID_W-1:0] cfg_id,
    input  logic [NUM_MB*RID_W-1:0] cfg_mask,
    input  logic [NUM_MB-1:0]       rearm_mask,
    input  logic [IDX_W-1:0]        rd_sel,
    output logic [NUM_MB-1:0]       mb_ready,
    output logic [NUM_MB-1:0]       mb_lost,
    output logic [NUM_MB-1:0]       mb_rx_irq,
    output logic                    overflow,
    output logic [31:0]             rd_status,
    output logic [RID_W-1:0]        rd_id,
    output logic [31:0]             rd_data_lo,
    output logic [31:0]             rd_data_hi
);

    logic [RID_W-1:0]     frame_id;
    logic [NUM_MB-1:0]    free_vec, ovr_vec, elig_vec;
    logic                 free_found, ovr_found;
    logic [IDX_W-1:0]     free_idx, ovr_idx;
    logic                 store, drop, over;
    logic [IDX_W-1:0]     tgt_idx;
    mb_rec_t              new_rec;
    mb_rec_t [NUM_MB-1:0] recs;
    mb_rec_t              sel_rec;
    logic                 sel_ready, sel_lost;

    assign frame_id = make_reg_id(frm_ext, frm_id);

    rxmb_filter #(.NUM_MB(NUM_MB)) u_filter (
        .frame_id (frame_id),
        .cfg_id   (cfg_id),
        .cfg_mask (cfg_mask),
        .cfg_mode (cfg_mode),
        .ready_q  (mb_ready),
        .free_o   (free_vec),
        .ovr_o    (ovr_vec),
        .elig_o   (elig_vec)
    );

    rxmb_first_set #(.NUM_MB(NUM_MB)) u_pick_free (
        .vec_i   (free_vec),
        .found_o (free_found),
        .idx_o   (free_idx)
    );

    rxmb_first_set #(.NUM_MB(NUM_MB)) u_pick_ovr (
        .vec_i   (ovr_vec),
        .found_o (ovr_found),
        .idx_o   (ovr_idx)
    );

    // An empty mailbox always wins over an overwrite. When none is empty,
    // every accepting overwrite mailbox is full, so taking one loses data.
    always_comb begin
        store   = frm_valid & (free_found | ovr_found);
        over    = ~free_found;
        tgt_idx = free_found ? free_idx : ovr_idx;
        drop    = frm_valid & (|elig_vec) & ~(free_found | ovr_found);
        new_rec = '{len: frm_len, rtr: frm_rtr, id: frame_id, data: frm_data};
    end

    rxmb_bank #(.NUM_MB(NUM_MB)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .store_i (store),
        .idx_i   (tgt_idx),
        .over_i  (over),
        .drop_i  (drop),
        .rearm_i (rearm_mask),
        .rec_i   (new_rec),
        .ready_o (mb_ready),
        .lost_o  (mb_lost),
        .irq_o   (mb_rx_irq),
        .ovf_o   (overflow),
        .rec_o   (recs)
    );

    always_comb begin
        sel_rec   = '0;
        sel_ready = 1'b0;
        sel_lost  = 1'b0;
        if (int'(rd_sel) < NUM_MB) begin
            sel_rec   = recs[rd_sel];
            sel_ready = mb_ready[rd_sel];
            sel_lost  = mb_lost[rd_sel];
        end
        rd_status  = {7'b0, sel_lost, sel_ready, 2'b0, sel_rec.rtr, sel_rec.len, 16'b0};
        rd_id      = sel_rec.id;
        rd_data_lo = sel_rec.data[31:0];
        rd_data_hi = sel_rec.data[63:32];
    end

endmodule

// File: rtl/rxmb_alloc_chk.sv
module rxmb_alloc_chk #(
    parameter int NUM_MB = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                frm_valid,
    input logic [2*NUM_MB-1:0] cfg_mode,
    input logic [NUM_MB-1:0]   rearm_mask,
    input logic [NUM_MB-1:0]   mb_ready,
    input logic [NUM_MB-1:0]   mb_lost,
    input logic [NUM_MB-1:0]   mb_rx_irq,
    input logic                overflow
);

    p_one_mb_per_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mb_rx_irq));

    p_irq_needs_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> (mb_rx_irq == '0));

    p_irq_marks_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_rx_irq & ~mb_ready) == '0);

    p_lost_needs_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_lost & ~mb_ready) == '0);

    p_overflow_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    p_rearm_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!frm_valid && rearm_mask != '0) |=> ((mb_ready & $past(rearm_mask)) == '0));

    for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
        p_off_no_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_mode[2*i+1] == cfg_mode[2*i]) |=> !mb_rx_irq[i]);

        p_full_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_mode[2*i +: 2] == 2'd1 && mb_ready[i] && !rearm_mask[i]) |=> !mb_rx_irq[i]);
    end

endmodule

bind rxmb_alloc rxmb_alloc_chk #(.NUM_MB(NUM_MB)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_valid  (frm_valid),
    .cfg_mode   (cfg_mode),
    .rearm_mask (rearm_mask),
    .mb_ready   (mb_ready),
    .mb_lost    (mb_lost),
    .mb_rx_irq  (mb_rx_irq),
    .overflow   (overflow)
);

// File: tb/rxmb_alloc_tb_top.sv
module rxmb_alloc_tb_top;

    localparam int N  = 8;
    localparam int IW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            frm_valid = 1'b0;
    logic            frm_ext = 1'b0;
    logic [28:0]     frm_id = '0;
    logic [3:0]      frm_len = '0;
    logic            frm_rtr = 1'b0;
    logic [63:0]     frm_data = '0;
    logic [2*N-1:0]  cfg_mode = '0;
    logic [N*30-1:0] cfg_id = '0;
    logic [N*30-1:0] cfg_mask = '0;
    logic [N-1:0]    rearm_mask = '0;
    logic [IW-1:0]   rd_sel = '0;
    logic [N-1:0]    mb_ready, mb_lost, mb_rx_irq;
    logic            overflow;
    logic [31:0]     rd_status, rd_data_lo, rd_data_hi;
    logic [29:0]     rd_id;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #4 clk = ~clk;   // 125 MHz

    rxmb_alloc #(.NUM_MB(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ext(frm_ext),
        .frm_id(frm_id), .frm_len(frm_len), .frm_rtr(frm_rtr), .frm_data(frm_data),
        .cfg_mode(cfg_mode), .cfg_id(cfg_id), .cfg_mask(cfg_mask),
        .rearm_mask(rearm_mask), .rd_sel(rd_sel), .mb_ready(mb_ready),
        .mb_lost(mb_lost), .mb_rx_irq(mb_rx_irq), .overflow(overflow),
        .rd_status(rd_status), .rd_id(rd_id), .rd_data_lo(rd_data_lo),
        .rd_data_hi(rd_data_hi)
    );

    // ---------------- behavioural reference model ----------------
    bit [N-1:0]  m_ready, m_lost, m_irq;
    bit          m_ovf;
    bit [3:0]    m_len  [N];
    bit          m_rtr  [N];
    bit [29:0]   m_id   [N];
    bit [63:0]   m_data [N];

    function automatic bit [29:0] fmt_id(bit ext, bit [28:0] id);
        return ext ? {1'b1, id} : {1'b0, id[10:0], 18'd0};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ready = '0; m_lost = '0; m_irq = '0; m_ovf = 1'b0;
            for (int i = 0; i < N; i++) begin
                m_len[i] = '0; m_rtr[i] = 1'b0; m_id[i] = '0; m_data[i] = '0;
            end
        end else begin
            int hit;
            bit over, any_acc;
            bit [29:0] fid;
            bit [N-1:0] pre_ready;
            hit = -1; over = 1'b0; any_acc = 1'b0;
            pre_ready = m_ready;
            fid = fmt_id(frm_ext, frm_id);
            m_irq = '0;
            m_ready = m_ready & ~rearm_mask;
            m_lost  = m_lost  & ~rearm_mask;
            if (frm_valid) begin
                for (int i = 0; i < N; i++) begin
                    bit [1:0] md;
                    bit acc;
                    md  = cfg_mode[2*i +: 2];
                    acc = ((fid ^ cfg_id[i*30 +: 30]) & cfg_mask[i*30 +: 30]) == 0;
                    if (acc && (md == 1 || md == 2)) any_acc = 1'b1;
                    if (hit < 0 && acc && (md == 1 || md == 2) && !pre_ready[i]) hit = i;
                end
                if (hit < 0) begin
                    for (int i = 0; i < N; i++) begin
                        if (hit < 0 && cfg_mode[2*i +: 2] == 2 &&
                            ((fid ^ cfg_id[i*30 +: 30]) & cfg_mask[i*30 +: 30]) == 0) begin
                            hit = i; over = 1'b1;
                        end
                    end
                end
                if (hit >= 0) begin
                    m_ready[hit] = 1'b1; m_lost[hit] = over; m_irq[hit] = 1'b1;
                    m_len[hit] = frm_len; m_rtr[hit] = frm_rtr;
                    m_id[hit] = fid; m_data[hit] = frm_data;
                end else if (any_acc) begin
                    m_ovf = 1'b1;
                end
            end
        end
    end

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at t=%0t", req, act, exp, $time);
        end
    endtask

    // Compare model and design every cycle, between edges.
    always @(posedge clk) begin
        #3;
        if (rst_n) begin
            check(mb_ready == m_ready, "R1 ready vector", 64'(mb_ready), 64'(m_ready));
            check(mb_lost == m_lost, "R4 lost vector", 64'(mb_lost), 64'(m_lost));
            check(mb_rx_irq == m_irq, "R8 irq vector", 64'(mb_rx_irq), 64'(m_irq));
            check(overflow == m_ovf, "R9 overflow", 64'(overflow), 64'(m_ovf));
            check(rd_status == {7'd0, m_lost[rd_sel], m_ready[rd_sel], 2'd0,
                                m_rtr[rd_sel], m_len[rd_sel], 16'd0},
                  "R6 status word", 64'(rd_status),
                  64'({7'd0, m_lost[rd_sel], m_ready[rd_sel], 2'd0, m_rtr[rd_sel], m_len[rd_sel], 16'd0}));
            check(rd_id == m_id[rd_sel], "R6 stored id", 64'(rd_id), 64'(m_id[rd_sel]));
            check({rd_data_hi, rd_data_lo} == m_data[rd_sel], "R6 data words",
                  {rd_data_hi, rd_data_lo}, m_data[rd_sel]);
        end
    end

    always @(negedge clk) begin
        if (!rst_n) rd_sel <= '0;
        else        rd_sel <= rd_sel + 1'b1;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL R11 watchdog expired actual=%0d expected<20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic set_mb(int i, bit [1:0] md, bit [29:0] id, bit [29:0] mk);
        cfg_mode[2*i +: 2] = md;
        cfg_id[i*30 +: 30] = id;
        cfg_mask[i*30 +: 30] = mk;
    endtask

    task automatic send(bit ext, bit [28:0] id, bit [3:0] len, bit rtr,
                        bit [63:0] data, bit [N-1:0] rearm = '0);
        @(negedge clk);
        frm_valid = 1'b1; frm_ext = ext; frm_id = id; frm_len = len;
        frm_rtr = rtr; frm_data = data; rearm_mask = rearm;
        @(negedge clk);
        frm_valid = 1'b0; rearm_mask = '0;
    endtask

    task automatic rearm(bit [N-1:0] m);
        @(negedge clk);
        rearm_mask = m;
        @(negedge clk);
        rearm_mask = '0;
    endtask

    localparam bit [29:0] ALL1 = 30'h3FFF_FFFF;

    initial begin
        set_mb(0, 2'd0, 30'd0, 30'd0);
        for (int i = 1; i <= 5; i++) set_mb(i, 2'd1, 30'd0, 30'd0);
        set_mb(6, 2'd1, fmt_id(1'b0, 29'h123), ALL1);
        set_mb(7, 2'd2, 30'd0, 30'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(mb_ready == 0 && mb_lost == 0, "R10 flags clear after reset", 64'({mb_ready, mb_lost}), 64'd0);
        check(overflow == 0 && mb_rx_irq == 0, "R10 overflow and irq clear", 64'({overflow, mb_rx_irq}), 64'd0);

        send(1'b0, 29'h010, 4'd8, 1'b0, 64'h0807_0605_0403_0201);
        check(mb_ready == 8'h02, "R1 R2 R11 first frame skips off mailbox 0", 64'(mb_ready), 64'h02);
        check(mb_rx_irq == 8'h02, "R8 pulse on mailbox 1", 64'(mb_rx_irq), 64'h02);
        @(negedge clk);
        check(mb_rx_irq == 8'h00, "R8 pulse lasts one cycle", 64'(mb_rx_irq), 64'h00);

        for (int k = 0; k < 4; k++) send(1'b0, 29'h011 + 29'(k), 4'(k + 1), k[0], {32'hA5A5_0000, 32'(k)});
        check(mb_ready == 8'h3E, "R1 R3 ascending fill", 64'(mb_ready), 64'h3E);

        send(1'b0, 29'h200, 4'd2, 1'b1, 64'h1111);
        check(mb_ready == 8'hBE && mb_lost == 0, "R1 R5 masked mailbox 6 skipped, empty overwrite used", 64'({mb_ready, mb_lost}), 64'hBE00);

        send(1'b0, 29'h201, 4'd3, 1'b0, 64'h2222);
        check(mb_lost == 8'h80 && mb_rx_irq == 8'h80, "R4 overwrite sets lost", 64'({mb_lost, mb_rx_irq}), 64'h8080);

        send(1'b0, 29'h123, 4'd4, 1'b0, 64'h3333);
        check(mb_ready == 8'hFE && mb_rx_irq == 8'h40, "R5 exact-match filter", 64'({mb_ready, mb_rx_irq}), 64'hFE40);

        // Only mailbox 6 enabled; frame it rejects must not count as overflow.
        for (int i = 1; i <= 5; i++) cfg_mode[2*i +: 2] = 2'd0;
        cfg_mode[15:14] = 2'd0;
        send(1'b0, 29'h124, 4'd1, 1'b0, 64'h4444);
        check(overflow == 0 && mb_ready == 8'hFE, "R9 rejected frame leaves overflow", 64'({overflow, mb_ready}), 64'hFE);

        for (int i = 1; i <= 5; i++) cfg_mode[2*i +: 2] = 2'd1;
        cfg_mode[15:14] = 2'd1;
        send(1'b0, 29'h300, 4'd1, 1'b0, 64'h5555);
        check(overflow == 1 && mb_ready == 8'hFE, "R3 R9 full bank drops frame", 64'({overflow, mb_ready}), 64'h1FE);

        rearm(8'h06);
        check(mb_ready == 8'hF8 && mb_lost == 8'h80, "R7 multi re-arm keeps others", 64'({mb_ready, mb_lost}), 64'hF880);
        rearm(8'h80);
        check(mb_ready == 8'h78 && mb_lost == 0, "R7 re-arm clears lost", 64'({mb_ready, mb_lost}), 64'h7800);

        send(1'b0, 29'h055, 4'd5, 1'b1, 64'h6666, 8'h08);
        check(mb_ready == 8'h72, "R7 same-cycle re-arm uses prior state", 64'(mb_ready), 64'h72);
        check(overflow == 1, "R9 overflow sticky", 64'(overflow), 64'd1);

        rearm(8'hFE);
        for (int i = 1; i <= 5; i++) cfg_mode[2*i +: 2] = 2'd0;
        set_mb(6, 2'd1, fmt_id(1'b1, 29'h1ABC_DE0), ALL1);
        set_mb(7, 2'd3, 30'd0, 30'd0);
        send(1'b1, 29'h1ABC_DE0, 4'd6, 1'b0, 64'hDEAD_BEEF_0BAD_F00D);
        check(mb_ready == 8'h40, "R5 extended match", 64'(mb_ready), 64'h40);
        send(1'b1, 29'h1ABC_DE1, 4'd6, 1'b0, 64'h7777);
        check(mb_ready == 8'h40 && mb_rx_irq == 0, "R2 R5 reserved mode and mismatch store nothing", 64'({mb_ready, mb_rx_irq}), 64'h4000);

        set_mb(5, 2'd1, fmt_id(1'b1, 29'h0F0F), 30'd0);
        send(1'b0, 29'h7FF, 4'd7, 1'b1, 64'h8888_9999);
        check(mb_ready == 8'h60, "R5 zero mask takes other format", 64'(mb_ready), 64'h60);

        repeat (N + 2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule